// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a slave on a two-wire serial bus (one clock line, one data line). It gives a bus master single-byte read and write access to a small register file held inside the block. The master opens a transfer with a START, sends the 7-bit device address and a direction bit, then sends a register pointer byte. For a write, one data byte follows and lands in the addressed register. For a read, the master issues a repeated START, sends the address again with the read bit set, and the block returns one byte.

Both bus lines are first passed through a two-flop synchronizer on the system clock. Edges and bus conditions are detected on the synchronized copies. The block never drives the data line high: it only pulls it low through an output-enable, and the line itself is open-drain. The block does not stretch the clock, does not answer general call and does not auto-increment the pointer.

Top module: `tw_reg_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and register k (k from 0 to NREG-1) holds the value 0x10 + k.
- R2: A falling data line while the clock is high is a START and starts address reception from any state, including in the middle of a transfer (repeated START). A rising data line while the clock is high is a STOP: the block goes idle and releases the data line.
- R3: The block acknowledges an address byte whose upper seven bits equal 1001000 by pulling the data line low for the ninth clock of that byte. Bit 0 of the address byte selects the direction, with 1 for read and 0 for write.
- R4: For any other address, the block does not acknowledge, drives nothing, and ignores every later bit until the next START. No register changes.
- R5: In a write, the byte after the address is the register pointer and the byte after that is the data. Both are received MSB first, both are acknowledged, and the data is stored in the register the pointer selects.
- R6: In a read (a pointer write, a repeated START, then the address with the read bit), the block returns the byte of the register the pointer selects, MSB first.
- R7: A pointer of NREG or above (8 with the default parameter) reads back as 0xFF. A write through such a pointer is acknowledged but changes no register.
- R8: After the eighth bit of a read byte, the block releases the data line. It keeps the line released for every further clock until a START, whether the master acknowledged the byte or not.
- R9: `sda_oe` changes only in the cycle after the synchronized clock falls, or after a START or STOP. It never changes while the clock is high during a data or acknowledge bit.
- R10: Access is one byte per transfer. A second data byte in the same write is not acknowledged and is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND of all drivers) |
| sda_oe | output | 1 | When 1, the pad pulls the data line low; when 0, the line is released |

## Verification
The assertions assume that the bus changes the data line only while the clock is low, except for START and STOP. They also assume that each clock level lasts several system clocks, so that no synchronized clock edge coincides with a condition. The bench keeps to both assumptions: every bus phase lasts 16 system clocks, data is changed a few cycles after the clock falls, and START and STOP are made only with the clock held high. With the data line modelled as a wired-AND of the master and the block, the bench observes each acknowledge and read bit just as a master would see it on the bus.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_HOLD
  } tw_state_e;

  // Address byte carries the device address in its upper seven bits.
  function automatic logic dev_match(input logic [7:0] addr_byte, input logic [6:0] dev);
    return addr_byte[7:1] == dev;
  endfunction

  // Power-up contents of register idx.
  function automatic logic [7:0] reg_init(input int unsigned idx);
    return 8'(32'h10 + idx);
  endfunction

  // Pointer decode: true when the pointer selects an implemented register.
  function automatic logic ptr_valid(input logic [7:0] ptr, input int unsigned nreg);
    return 32'(ptr) < nreg;
  endfunction
endpackage

// File: rtl/tw_sync.sv
`timescale 1ns/1ps
module tw_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;

  // Idle bus lines are high, so reset to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '1;
      q_o  <= '1;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/tw_line_events.sv
`timescale 1ns/1ps
module tw_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  logic scl_held_high;
  assign scl_held_high = scl_s & scl_p;
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_held_high & sda_p & ~sda_s;
  assign stop_ev  = scl_held_high & ~sda_p & sda_s;
endmodule

// File: rtl/tw_regfile.sv
`timescale 1ns/1ps
module tw_regfile import tw_pkg::*; #(
  parameter int NREG = 8,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    ptr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DW-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= DW'(reg_init(i));
      else if (wr_en && ptr == 8'(i))
        mem[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '1;
    if (ptr_valid(ptr, NREG))
      rd_data = mem[ptr[IDXW-1:0]];
  end
endmodule

// File: rtl/tw_reg_slave.sv
`timescale 1ns/1ps
module tw_reg_slave import tw_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'b1001000,
  parameter int         NREG     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int DW = 8;

  logic [1:0] line_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_ev, stop_ev;

  tw_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  tw_line_events u_ev (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  tw_state_e     state;
  logic [2:0]    bit_cnt;
  logic [DW-1:0] shreg;
  logic [7:0]    ptr;
  logic          rd_dir;
  logic [DW-1:0] rx_byte;
  logic [DW-1:0] rd_data;
  logic          byte_done;
  logic          wr_en;

  assign rx_byte   = {shreg[DW-2:0], sda_s};
  assign byte_done = scl_rise && (bit_cnt == 3'd7);
  assign wr_en     = (state == ST_WDAT) && byte_done;

  tw_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .ptr     (ptr),
    .wr_data (rx_byte),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      ptr     <= '0;
      rd_dir  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_ev) begin
      state   <= ST_DEV;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_DEV, ST_PTR, ST_WDAT: begin
          if (scl_rise) begin
            shreg   <= rx_byte;
            bit_cnt <= bit_cnt + 3'd1;
            if (byte_done) begin
              if (state == ST_DEV) begin
                if (dev_match(rx_byte, DEV_ADDR)) begin
                  rd_dir <= rx_byte[0];
                  state  <= ST_DEV_ACK;
                end else begin
                  state <= ST_HOLD;
                end
              end else if (state == ST_PTR) begin
                ptr   <= rx_byte;
                state <= ST_PTR_ACK;
              end else begin
                state <= ST_WDAT_ACK;
              end
            end
          end
        end
        ST_DEV_ACK, ST_PTR_ACK, ST_WDAT_ACK: begin
          // First fall closes the eighth bit: pull low. Second fall closes the ack.
          if (scl_fall) begin
            if (!sda_oe) begin
              sda_oe <= 1'b1;
            end else begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              if (state == ST_DEV_ACK) begin
                if (rd_dir) begin
                  state  <= ST_RDAT;
                  shreg  <= rd_data;
                  sda_oe <= ~rd_data[DW-1];
                end else begin
                  state <= ST_PTR;
                end
              end else if (state == ST_PTR_ACK) begin
                state <= ST_WDAT;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_oe <= 1'b0;
              state  <= ST_HOLD;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              shreg   <= {shreg[DW-2:0], 1'b0};
              sda_oe  <= ~shreg[DW-2];
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tw_reg_slave_chk.sv
`timescale 1ns/1ps
module tw_reg_slave_chk import tw_pkg::*; (
  input logic      clk,
  input logic      rst_n,
  input logic      scl_s,
  input logic      scl_rise,
  input logic      scl_fall,
  input logic      start_ev,
  input logic      stop_ev,
  input logic      wr_en,
  input logic      sda_oe,
  input tw_state_e state
);
  p_start_dev_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == ST_DEV && !sda_oe));

  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE && !sda_oe));

  p_events_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_ev, stop_ev, scl_rise, scl_fall}));

  p_write_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (state == ST_WDAT_ACK));

  p_hold_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> !sda_oe);

  p_oe_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_ev) || $past(stop_ev)));

  p_oe_rise_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
endmodule

bind tw_reg_slave tw_reg_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .scl_rise (scl_rise),
  .scl_fall (scl_fall),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .wr_en    (wr_en),
  .sda_oe   (sda_oe),
  .state    (state)
);

// File: tb/sim_tw_reg_slave.sv
`timescale 1ns/1ps
module sim_tw_reg_slave;
  localparam int          H   = 16;
  localparam logic [6:0]  DEV = 7'b1001000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  wire  sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  tw_reg_slave u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_m),
    .sda_i  (sda_bus),
    .sda_oe (sda_oe)
  );

  int checks = 0, errors = 0, glitches = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;
  exp_t       exp_q[$];
  logic [7:0] obs_q[$];
  event       obs_ev;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input logic [7:0] v, input string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic observe(input logic [7:0] v);
    obs_q.push_back(v);
    ->obs_ev;
  endtask

  // Scoreboard monitor.
  initial begin
    forever begin
      @(obs_ev);
      while (obs_q.size() > 0) begin
        logic [7:0] o;
        o = obs_q.pop_front();
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL scoreboard actual %02h expected none", o);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(e.tag, o, e.v);
        end
      end
    end
  end

  task automatic xfer_bit(input logic b, output logic smp);
    logic o1;
    sda_m = b;
    hold(H);
    scl_m = 1'b1;
    hold(H / 4);
    o1 = sda_oe;
    hold(H / 4);
    smp = sda_bus;
    hold(H / 4);
    if (sda_oe !== o1) glitches++;
    hold(H / 4);
    scl_m = 1'b0;
    hold(4);
  endtask

  task automatic bus_start();
    sda_m = 1'b1;
    hold(H);
    scl_m = 1'b1;
    hold(H);
    sda_m = 1'b0;
    hold(H);
    scl_m = 1'b0;
    hold(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0;
    hold(H);
    scl_m = 1'b1;
    hold(H);
    sda_m = 1'b1;
    hold(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic s;
    for (int i = 7; i >= 0; i--) xfer_bit(b[i], s);
    expect_item({7'b0, exp_ack}, tag);
    xfer_bit(1'b1, s);
    observe({7'b0, ~s});
  endtask

  task automatic recv_byte(input logic [7:0] exp_v, input logic mack, input string tag);
    logic s;
    logic [7:0] v;
    v = '0;
    expect_item(exp_v, tag);
    for (int i = 0; i < 8; i++) begin
      xfer_bit(1'b1, s);
      v = {v[6:0], s};
    end
    xfer_bit(~mack, s);
    observe(v);
  endtask

  task automatic reg_write(input logic [6:0] dev, input logic [7:0] ptr, input logic [7:0] d,
                           input logic ack_all, input string tag);
    bus_start();
    send_byte({dev, 1'b0}, ack_all, tag);
    send_byte(ptr, ack_all, tag);
    send_byte(d, ack_all, tag);
    bus_stop();
  endtask

  task automatic reg_read(input logic [7:0] ptr, input logic [7:0] exp_v, input string tag);
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, tag);
    send_byte(ptr, 1'b1, tag);
    bus_start();
    send_byte({DEV, 1'b1}, 1'b1, tag);
    recv_byte(exp_v, 1'b0, tag);
    bus_stop();
  endtask

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    hold(5);
    chk("R1 oe in reset", {7'b0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    hold(10);
    chk("R1 oe after reset", {7'b0, sda_oe}, 8'h00);

    // R1 / R6 / R3: power-up contents through reads.
    for (int k = 0; k < 8; k++) reg_read(8'(k), 8'(8'h10 + k), "R1 R6 init read");

    // R5: writes, including the last implemented register.
    reg_write(DEV, 8'h03, 8'hA5, 1'b1, "R5 write 3");
    reg_read(8'h03, 8'hA5, "R5 readback 3");
    reg_write(DEV, 8'h07, 8'h3C, 1'b1, "R5 write 7");
    reg_read(8'h07, 8'h3C, "R5 readback 7");

    // R7: unimplemented pointers.
    reg_read(8'h08, 8'hFF, "R7 read ptr 8");
    reg_read(8'hF3, 8'hFF, "R7 read ptr F3");
    reg_write(DEV, 8'h08, 8'h00, 1'b1, "R7 write ptr 8");
    reg_read(8'h00, 8'h10, "R7 reg0 untouched");

    // R4: wrong device addresses.
    reg_write(7'b1001001, 8'h05, 8'h00, 1'b0, "R4 addr 49");
    reg_write(7'b0001000, 8'h05, 8'h00, 1'b0, "R4 addr 08");
    reg_read(8'h05, 8'h15, "R4 reg5 untouched");
    chk("R4 oe released", {7'b0, sda_oe}, 8'h00);

    // R10: second data byte refused.
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R10 addr");
    send_byte(8'h02, 1'b1, "R10 ptr");
    send_byte(8'h77, 1'b1, "R10 first data");
    send_byte(8'h99, 1'b0, "R10 second data");
    bus_stop();
    reg_read(8'h02, 8'h77, "R10 readback");

    // R8: master acks the read byte, then clocks another byte.
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R8 addr");
    send_byte(8'h02, 1'b1, "R8 ptr");
    bus_start();
    send_byte({DEV, 1'b1}, 1'b1, "R8 raddr");
    recv_byte(8'h77, 1'b1, "R8 data acked");
    recv_byte(8'hFF, 1'b0, "R8 line released");
    bus_stop();
    reg_read(8'h04, 8'h14, "R8 recovery read");

    // R2: repeated START right after a write, no STOP between.
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2 addr");
    send_byte(8'h01, 1'b1, "R2 ptr");
    send_byte(8'h5A, 1'b1, "R2 data");
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2 addr again");
    send_byte(8'h01, 1'b1, "R2 ptr again");
    bus_start();
    send_byte({DEV, 1'b1}, 1'b1, "R2 raddr");
    recv_byte(8'h5A, 1'b0, "R2 read after rstart");
    bus_stop();

    // R2: STOP after pointer aborts the write.
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2 abort addr");
    send_byte(8'h04, 1'b1, "R2 abort ptr");
    bus_stop();
    chk("R2 oe after stop", {7'b0, sda_oe}, 8'h00);
    reg_read(8'h04, 8'h14, "R2 reg4 unchanged");

    hold(10);
    chk("R9 oe stable while clock high", 8'(glitches), 8'h00);
    chk("scoreboard drained", 8'(exp_q.size()), 8'h00);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule